// File: doc/BRIEF.md
# Flash Command, Status and Interrupt Unit

This block is the register-level control core of a NAND-style flash device as a host sees it over a 16-bit register bus. It holds a command register, a controller status register with error flags, an interrupt status register, two configuration registers and a start-buffer register. The host writes a command code. The unit decodes it and then takes one of three paths. Array commands (load, program, erase) go to an external operation engine through a start pulse. The engine returns a done pulse and a fail flag. Housekeeping commands finish at once. Reset commands restore the register set.

Completion shows up in the interrupt status register, and also on an interrupt pin. Configuration sets the polarity of that pin. The host takes back control by clearing the master interrupt bit with an AND-write. No new command is taken while that bit is set, or while an engine operation is still outstanding.

Register select codes on `reg_sel`: 0 command, 1 configuration-1, 2 configuration-2, 3 controller status, 4 interrupt status, 5 start-buffer. Other codes read as zero and ignore writes.

Top module: `flash_cmd_core`

## Requirements
- R1: After the cold reset (`rst_n` low), the register reads are as follows: interrupt status 0x8080, configuration-1 0x40C0, configuration-2 0x0000, status 0x0000, command 0x0000 and start-buffer 0x0001.
- R2: Two events perform a warm reset: a one-cycle `warm_rst`, or an accepted command 0x00F0 or 0x00F3. A warm reset restores the R1 values, except that interrupt status becomes 0x8010.
- R3: `irq` equals interrupt-status bit 15 XOR the inverse of configuration-1 bit 6. With bit 6 set, the pin is active high. Any change shows in the cycle after the clock edge that caused it.
- R4: `ready` is configuration-1 bit 7 while `op_busy` is low. It is 0 whenever `op_busy` is high.
- R5: Configuration-1 reads back with bits 4:0 forced to zero. Configuration-2 reads back exactly as written.
- R6: A start-buffer write takes bits 11:8 as `buf_addr` and bits 1:0 as the sector count. `sec_count` is 4 when the field is 0, and the field value otherwise. A read returns only those two fields.
- R7: A command write does nothing in two cases: when interrupt-status bit 15 is set, or when an engine operation is outstanding. In both cases the command register and `op_start` stay unchanged.
- R8: A write to interrupt status ANDs the written value into the register. If bit 15 is then clear, status bits 13:10 are cleared.
- R9: An accepted array command raises `op_start` for exactly one cycle, starting at the edge that accepts it, with `op_code` equal to the command. The array commands are: load 0x00 and 0x13, program 0x80, 0x1A and 0x1B, erase 0x94 and 0x95.
- R10: An `op_done` pulse while an operation is outstanding does two things. It sets interrupt bit 15 and the kind bit: 7 for load, 6 for program, 5 for erase. If `op_fail` is high, it also sets status bit 10 and the kind error bit: 13 for load, 12 for program, 11 for erase.
- R11: The remaining command codes behave as follows:
  - Codes 0x23, 0x27, 0x2A, 0x2C, 0x71 and 0x65 set interrupt bit 15 only.
  - 0x30 sets bits 15 and 5.
  - 0xB0 changes nothing but the command register.
  - Any other code sets status bit 10 and interrupt bit 15.
- R12: When `op_done` and a host interrupt-status write fall in the same cycle, the AND is applied first. The done bits therefore survive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Cold reset, active low, synchronous |
| warm_rst | input | 1 | Warm reset request, active high, synchronous |
| reg_sel | input | 3 | Register select for read and write |
| wr_en | input | 1 | Write strobe for the selected register |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Read data of the selected register (combinational) |
| op_busy | input | 1 | Engine busy |
| op_done | input | 1 | Engine completion pulse |
| op_fail | input | 1 | Engine failure flag, valid with op_done |
| op_start | output | 1 | One-cycle start pulse to the engine |
| op_code | output | 8 | Command code handed to the engine |
| irq | output | 1 | Interrupt pin, polarity from configuration-1 bit 6 |
| ready | output | 1 | Ready pin |
| buf_addr | output | 4 | Buffer address from start-buffer |
| sec_count | output | 3 | Sector count, 1 to 4 |

## Verification
Every register-held result appears one clock edge after its stimulus: written registers, `op_start`, completion bits and error flags. `irq` and `ready` derive without delay from those registers (and from `op_busy`), so they also show their new value right after that same edge. `rd_data` is a combinational mux. The bench drives every stimulus on a falling edge and lets exactly one rising edge pass. It then checks the outputs and reads on the next falling edge, one time unit after changing `reg_sel`. `op_start` is checked both in that cycle and in the cycle after, to confirm the pulse is single. For the same-cycle case, the done pulse and the interrupt write are driven on the same falling edge.

// File: rtl/fcc_pkg.sv
package fcc_pkg;
    localparam int DW = 16;
    localparam int SEL_W = 3;

    localparam logic [SEL_W-1:0] SEL_CMD  = 3'd0;
    localparam logic [SEL_W-1:0] SEL_CFG1 = 3'd1;
    localparam logic [SEL_W-1:0] SEL_CFG2 = 3'd2;
    localparam logic [SEL_W-1:0] SEL_STAT = 3'd3;
    localparam logic [SEL_W-1:0] SEL_INT  = 3'd4;
    localparam logic [SEL_W-1:0] SEL_SBUF = 3'd5;

    localparam int IB_MASTER = 15;
    localparam int IB_ERASE  = 5;
    localparam int IB_PROG   = 6;
    localparam int IB_LOAD   = 7;
    localparam int EB_CMD    = 10;
    localparam int EB_ERASE  = 11;
    localparam int EB_PROG   = 12;
    localparam int EB_LOAD   = 13;

    localparam logic [DW-1:0] CFG1_INIT = 16'h40C0;
    localparam logic [DW-1:0] INT_COLD  = 16'h8080;
    localparam logic [DW-1:0] INT_WARM  = 16'h8010;
    localparam int CFG1_LO = 5;

    typedef enum logic [2:0] {
        CL_NOP, CL_ARRAY, CL_RESUME, CL_IMM, CL_RESET, CL_BAD
    } cmd_class_e;

    typedef enum logic [1:0] {K_LOAD, K_PROG, K_ERASE} op_kind_e;

    typedef struct packed {
        logic [DW-1:0]      cmd;
        logic [DW-1:CFG1_LO] cfg1;
        logic [DW-1:0]      cfg2;
        logic [DW-1:0]      stat;
        logic [DW-1:0]      intr;
        logic [3:0]         bufa;
        logic [1:0]         cnt;
        logic               pend;
        op_kind_e           kind;
        logic               start;
        logic [7:0]         opc;
    } core_st_t;

    function automatic core_st_t warm_state();
        core_st_t s;
        s = '0;
        s.cfg1 = CFG1_INIT[DW-1:CFG1_LO];
        s.intr = INT_WARM;
        s.cnt  = 2'd1;
        s.kind = K_LOAD;
        return s;
    endfunction
endpackage

// File: rtl/fcc_cmd_decode.sv
module fcc_cmd_decode
    import fcc_pkg::*;
(
    input  logic [DW-1:0] code,
    output cmd_class_e    cls,
    output op_kind_e      kind
);
    always_comb begin
        cls  = CL_BAD;
        kind = K_LOAD;
        if (code[DW-1:8] == '0) begin
            unique case (code[7:0])
                8'h00, 8'h13:        begin cls = CL_ARRAY; kind = K_LOAD;  end
                8'h80, 8'h1A, 8'h1B: begin cls = CL_ARRAY; kind = K_PROG;  end
                8'h94, 8'h95:        begin cls = CL_ARRAY; kind = K_ERASE; end
                8'h30:               cls = CL_RESUME;
                8'h23, 8'h27, 8'h2A, 8'h2C, 8'h71, 8'h65: cls = CL_IMM;
                8'hB0:               cls = CL_NOP;
                8'hF0, 8'hF3:        cls = CL_RESET;
                default:             cls = CL_BAD;
            endcase
        end
    end
endmodule

// File: rtl/fcc_pins.sv
module fcc_pins (
    input  logic clk,
    input  logic rst_n,
    input  logic int_master,
    input  logic pol_high,
    input  logic rdy_cfg,
    input  logic op_busy,
    output logic irq,
    output logic ready
);
    always_comb begin
        irq   = int_master ^ ~pol_high;
        ready = rdy_cfg & ~op_busy;
    end

    a_r4_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
        op_busy |-> !ready);
endmodule

// File: rtl/flash_cmd_core.sv
module flash_cmd_core
    import fcc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             warm_rst,
    input  logic [SEL_W-1:0] reg_sel,
    input  logic             wr_en,
    input  logic [DW-1:0]    wr_data,
    output logic [DW-1:0]    rd_data,
    input  logic             op_busy,
    input  logic             op_done,
    input  logic             op_fail,
    output logic             op_start,
    output logic [7:0]       op_code,
    output logic             irq,
    output logic             ready,
    output logic [3:0]       buf_addr,
    output logic [2:0]       sec_count
);
    core_st_t   st_d, st_q;
    cmd_class_e dec_cls;
    op_kind_e   dec_kind;
    logic       cmd_ok;

    fcc_cmd_decode u_dec (
        .code (wr_data),
        .cls  (dec_cls),
        .kind (dec_kind)
    );

    assign cmd_ok = wr_en && (reg_sel == SEL_CMD) && !st_q.intr[IB_MASTER] && !st_q.pend;

    always_comb begin
        st_d       = st_q;
        st_d.start = 1'b0;

        if (wr_en) begin
            unique case (reg_sel)
                SEL_CMD: if (cmd_ok) begin
                    st_d.cmd = wr_data;
                    unique case (dec_cls)
                        CL_ARRAY: begin
                            st_d.pend  = 1'b1;
                            st_d.kind  = dec_kind;
                            st_d.start = 1'b1;
                            st_d.opc   = wr_data[7:0];
                        end
                        CL_RESUME: begin
                            st_d.intr[IB_MASTER] = 1'b1;
                            st_d.intr[IB_ERASE]  = 1'b1;
                        end
                        CL_IMM:   st_d.intr[IB_MASTER] = 1'b1;
                        CL_RESET: st_d = warm_state();
                        CL_BAD: begin
                            st_d.stat[EB_CMD]    = 1'b1;
                            st_d.intr[IB_MASTER] = 1'b1;
                        end
                        default: ;
                    endcase
                end
                SEL_CFG1: st_d.cfg1 = wr_data[DW-1:CFG1_LO];
                SEL_CFG2: st_d.cfg2 = wr_data;
                SEL_INT: begin
                    st_d.intr = st_q.intr & wr_data;
                    if (!st_d.intr[IB_MASTER])
                        st_d.stat[EB_LOAD:EB_CMD] = '0;
                end
                SEL_SBUF: begin
                    st_d.bufa = wr_data[11:8];
                    st_d.cnt  = wr_data[1:0];
                end
                default: ;
            endcase
        end

        // completion is merged after the host AND so its bits survive
        if (st_q.pend && op_done) begin
            st_d.pend            = 1'b0;
            st_d.intr[IB_MASTER] = 1'b1;
            unique case (st_q.kind)
                K_LOAD:  st_d.intr[IB_LOAD]  = 1'b1;
                K_PROG:  st_d.intr[IB_PROG]  = 1'b1;
                default: st_d.intr[IB_ERASE] = 1'b1;
            endcase
            if (op_fail) begin
                st_d.stat[EB_CMD] = 1'b1;
                unique case (st_q.kind)
                    K_LOAD:  st_d.stat[EB_LOAD]  = 1'b1;
                    K_PROG:  st_d.stat[EB_PROG]  = 1'b1;
                    default: st_d.stat[EB_ERASE] = 1'b1;
                endcase
            end
        end

        if (warm_rst) st_d = warm_state();
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= warm_state();
            st_q.intr <= INT_COLD;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        unique case (reg_sel)
            SEL_CMD:  rd_data = st_q.cmd;
            SEL_CFG1: rd_data = {st_q.cfg1, {CFG1_LO{1'b0}}};
            SEL_CFG2: rd_data = st_q.cfg2;
            SEL_STAT: rd_data = st_q.stat;
            SEL_INT:  rd_data = st_q.intr;
            SEL_SBUF: rd_data = {4'h0, st_q.bufa, 6'h00, st_q.cnt};
            default:  rd_data = '0;
        endcase
    end

    assign op_start  = st_q.start;
    assign op_code   = st_q.opc;
    assign buf_addr  = st_q.bufa;
    assign sec_count = (st_q.cnt == 2'd0) ? 3'd4 : {1'b0, st_q.cnt};

    fcc_pins u_pins (
        .clk        (clk),
        .rst_n      (rst_n),
        .int_master (st_q.intr[IB_MASTER]),
        .pol_high   (st_q.cfg1[6]),
        .rdy_cfg    (st_q.cfg1[7]),
        .op_busy    (op_busy),
        .irq        (irq),
        .ready      (ready)
    );

    a_r7_cmd_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && reg_sel == SEL_CMD && (st_q.intr[IB_MASTER] || st_q.pend) && !warm_rst)
        |=> ($stable(st_q.cmd) && !op_start));

    a_r8_err_wipe: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && reg_sel == SEL_INT && !wr_data[IB_MASTER] && !(op_done && st_q.pend) && !warm_rst)
        |=> (st_q.stat[EB_LOAD:EB_CMD] == 4'h0));

    a_r9_single_start: assert property (@(posedge clk) disable iff (!rst_n)
        op_start |=> !op_start);

    a_r10_done_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (op_done && st_q.pend && !warm_rst) |=> (st_q.intr[IB_MASTER] && !st_q.pend));

    a_r2_warm_value: assert property (@(posedge clk) disable iff (!rst_n)
        warm_rst |=> (st_q.intr == INT_WARM));
endmodule

// File: tb/sim_flash_cmd_core.sv
`timescale 1ns/1ps
module sim_flash_cmd_core;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0, warm_rst = 1'b0;
    logic [2:0]  reg_sel = 3'd0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = 16'h0;
    logic [15:0] rd_data;
    logic        op_busy = 1'b0, op_done = 1'b0, op_fail = 1'b0;
    logic        op_start, irq, ready;
    logic [7:0]  op_code;
    logic [3:0]  buf_addr;
    logic [2:0]  sec_count;
    int total = 0, bad = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    flash_cmd_core u0 (.*);

    function automatic logic exp_irq(input logic [15:0] iv, input logic [15:0] c1);
        return iv[15] ^ ~c1[6];
    endfunction
    function automatic logic [2:0] exp_cnt(input logic [1:0] f);
        return (f == 2'd0) ? 3'd4 : {1'b0, f};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic rd(input logic [2:0] s, output logic [15:0] v);
        reg_sel = s;
        #1 v = rd_data;
    endtask

    task automatic wr(input logic [2:0] s, input logic [15:0] d);
        @(negedge clk);
        reg_sel = s; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic chk_reg(input string tag, input logic [2:0] s, input logic [15:0] e);
        logic [15:0] v;
        rd(s, v);
        chk(tag, v, e);
    endtask

    task automatic run_op(input logic [15:0] code, input logic fail,
                          input logic [15:0] e_int, input logic [15:0] e_stat);
        wr(3'd0, code);
        chk("R9 op_start", op_start, 1'b1);
        chk("R9 op_code", op_code, code[7:0]);
        op_busy = 1'b1;
        @(negedge clk);
        chk("R9 single pulse", op_start, 1'b0);
        chk("R4 busy ready", ready, 1'b0);
        wr(3'd0, 16'h0080);
        chk_reg("R7 pending blocks cmd", 3'd0, code);
        chk("R7 no start", op_start, 1'b0);
        @(negedge clk);
        op_busy = 1'b0; op_done = 1'b1; op_fail = fail;
        @(negedge clk);
        op_done = 1'b0; op_fail = 1'b0;
        chk_reg("R10 int", 3'd4, e_int);
        chk_reg("R10 stat", 3'd3, e_stat);
        chk("R3 irq", irq, exp_irq(e_int, 16'h40C0));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog act=hung exp=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int unsigned seed;
        seed = $urandom(32'd2718);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 cold reset values
        chk_reg("R1 int", 3'd4, 16'h8080);
        chk_reg("R1 cfg1", 3'd1, 16'h40C0);
        chk_reg("R1 cfg2", 3'd2, 16'h0000);
        chk_reg("R1 stat", 3'd3, 16'h0000);
        chk_reg("R1 cmd", 3'd0, 16'h0000);
        chk_reg("R1 sbuf", 3'd5, 16'h0001);
        chk("R3 irq cold", irq, 1'b1);
        chk("R4 ready cold", ready, 1'b1);

        // R7 master bit set blocks commands
        wr(3'd0, 16'h0094);
        chk("R7 no start", op_start, 1'b0);
        chk_reg("R7 cmd kept", 3'd0, 16'h0000);

        // R8 clear master
        wr(3'd4, 16'h0000);
        chk_reg("R8 int cleared", 3'd4, 16'h0000);
        chk("R3 irq low", irq, 1'b0);

        // R3 R4 R5 random configuration
        for (int i = 0; i < 40; i++) begin
            logic [15:0] c1, c2;
            logic b;
            c1 = 16'($urandom); c2 = 16'($urandom); b = 1'($urandom);
            wr(3'd1, c1);
            wr(3'd2, c2);
            op_busy = b;
            #1;
            chk_reg("R5 cfg1 read", 3'd1, c1 & 16'hFFE0);
            chk_reg("R5 cfg2 read", 3'd2, c2);
            chk("R3 irq polarity", irq, exp_irq(16'h0000, c1));
            chk("R4 ready", ready, c1[7] & ~b);
            op_busy = 1'b0;
        end
        wr(3'd1, 16'h40C0);

        // R6 start-buffer random
        for (int i = 0; i < 20; i++) begin
            logic [15:0] v;
            v = 16'($urandom);
            wr(3'd5, v);
            chk("R6 buf_addr", buf_addr, v[11:8]);
            chk("R6 sec_count", sec_count, exp_cnt(v[1:0]));
            chk_reg("R6 sbuf read", 3'd5, v & 16'h0F03);
        end

        // R9 R10 load fail, program ok, erase fail
        run_op(16'h0000, 1'b1, 16'h8080, 16'h2400);
        wr(3'd4, 16'h7FFF);
        chk_reg("R8 and keep", 3'd4, 16'h0080);
        chk_reg("R8 errors wiped", 3'd3, 16'h0000);
        wr(3'd4, 16'h0000);
        run_op(16'h0080, 1'b0, 16'h8040, 16'h0000);
        wr(3'd4, 16'h0000);
        run_op(16'h0094, 1'b1, 16'h8020, 16'h0C00);
        wr(3'd4, 16'h8000);
        chk_reg("R8 master kept", 3'd4, 16'h8000);
        chk_reg("R8 errors kept", 3'd3, 16'h0C00);
        wr(3'd4, 16'h0000);
        chk_reg("R8 errors wiped", 3'd3, 16'h0000);

        // R11 other codes
        wr(3'd0, 16'h0055);
        chk_reg("R11 bad stat", 3'd3, 16'h0400);
        chk_reg("R11 bad int", 3'd4, 16'h8000);
        chk("R11 bad no start", op_start, 1'b0);
        wr(3'd4, 16'h0000);
        wr(3'd0, 16'h0180);
        chk_reg("R11 upper bits bad", 3'd3, 16'h0400);
        wr(3'd4, 16'h0000);
        wr(3'd0, 16'h002C);
        chk_reg("R11 imm int", 3'd4, 16'h8000);
        chk_reg("R11 imm stat", 3'd3, 16'h0000);
        wr(3'd4, 16'h0000);
        wr(3'd0, 16'h00B0);
        chk_reg("R11 nop int", 3'd4, 16'h0000);
        chk_reg("R11 nop cmd", 3'd0, 16'h00B0);
        wr(3'd0, 16'h0030);
        chk_reg("R11 resume int", 3'd4, 16'h8020);
        wr(3'd4, 16'h0000);

        // R12 done with simultaneous interrupt write
        wr(3'd0, 16'h0013);
        op_busy = 1'b1;
        @(negedge clk);
        op_busy = 1'b0; op_done = 1'b1;
        reg_sel = 3'd4; wr_data = 16'h0000; wr_en = 1'b1;
        @(negedge clk);
        op_done = 1'b0; wr_en = 1'b0;
        chk_reg("R12 done survives", 3'd4, 16'h8080);
        wr(3'd4, 16'h0000);

        // R2 reset command
        wr(3'd1, 16'h0000);
        chk("R3 irq active low idle", irq, 1'b1);
        wr(3'd2, 16'h1234);
        wr(3'd5, 16'h0302);
        wr(3'd0, 16'h00F3);
        chk_reg("R2 cmd reset int", 3'd4, 16'h8010);
        chk_reg("R2 cmd reset cfg1", 3'd1, 16'h40C0);
        chk_reg("R2 cmd reset cfg2", 3'd2, 16'h0000);
        chk_reg("R2 cmd reset sbuf", 3'd5, 16'h0001);
        chk_reg("R2 cmd reset cmd", 3'd0, 16'h0000);
        wr(3'd4, 16'h0000);
        wr(3'd0, 16'h00F0);
        chk_reg("R2 core reset int", 3'd4, 16'h8010);
        wr(3'd4, 16'h0000);
        wr(3'd2, 16'h5555);
        @(negedge clk);
        warm_rst = 1'b1;
        @(negedge clk);
        warm_rst = 1'b0;
        chk_reg("R2 pin int", 3'd4, 16'h8010);
        chk_reg("R2 pin cfg2", 3'd2, 16'h0000);
        chk("R3 irq after warm", irq, 1'b1);

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule